// File: doc/BRIEF.md
# Cascadable Slice Carry Chain

This block is a combinational carry path built from fixed segments of four bit positions. In each position a multiplexer picks the carry for the next position up. A propagate term steers that multiplexer, and an XOR of the propagate term with the incoming carry forms the sum bit. An operand stage in front of the chain derives the propagate and generate terms from two operand words and a mode. The segments are stacked through a generate loop, so the carry leaving the top of one segment enters the bottom of the next.

The same path serves four modes:

- **Add:** the bottom carry is chosen from constant 0, constant 1 or an external carry pin.
- **Subtract:** the carry into the chain is fixed at 1.
- **Wide AND:** the final carry reduces operand A by AND. Operand B and the carry select are not used.
- **Wide OR:** the final carry reduces operand A by OR. Operand B and the carry select are not used.

All per-position carries are brought out. They can feed a wider chain or be observed directly.

Top module: `carry_chain_top`

## Requirements
- R1: With mode_i = 0 (add), {cout_o, sum_o} equals op_a_i + op_b_i + c, where c is the bottom carry chosen by R2.
- R2: In add mode, cin_sel_i = 0 gives a bottom carry of 0, 1 gives 1, 2 gives carry_ext_i, and 3 behaves as 0.
- R3: With mode_i = 1 (subtract), {cout_o, sum_o} equals op_a_i + ~op_b_i + 1. So sum_o is op_a_i - op_b_i and cout_o is 1 exactly when op_a_i >= op_b_i, whatever cin_sel_i and carry_ext_i are.
- R4: With mode_i = 2 (wide AND), cout_o equals the AND of all bits of op_a_i. op_b_i, cin_sel_i and carry_ext_i have no effect on it.
- R5: With mode_i = 3 (wide OR), cout_o equals the OR of all bits of op_a_i. op_b_i, cin_sel_i and carry_ext_i have no effect on it.
- R6: In add and subtract modes, carry_o[i] is the carry leaving bit position i. That is bit i+1 of the sum of the low i+1 bits of both effective operands plus the bottom carry. This holds across segment boundaries at positions 3, 7, 11, and so on.
- R7: cout_o always equals carry_o[W-1], the carry leaving the highest position of the top segment.
- R8: In add mode, every position where op_a_i and op_b_i agree outputs a carry equal to op_a_i at that position, regardless of the carry arriving from below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | W (16) | Operand A; the word reduced in wide-logic modes |
| op_b_i | input | W (16) | Operand B; unused in wide-logic modes |
| mode_i | input | 2 | 0 add, 1 subtract, 2 wide AND, 3 wide OR |
| cin_sel_i | input | 2 | Bottom carry select in add mode: 0 zero, 1 one, 2 external, 3 zero |
| carry_ext_i | input | 1 | External carry for the bottom segment |
| sum_o | output | W (16) | Sum bits |
| carry_o | output | W (16) | Carry leaving each bit position |
| cout_o | output | 1 | Carry leaving the top segment |

## Verification
Random operand pairs in add mode, over all three bottom-carry choices, separate the carry select paths and show the carry crossing every segment boundary. Directed patterns add precise cases:

- **All-ones plus one:** forces a carry through all sixteen positions.
- **Equal operands:** isolates the generate side of each multiplexer from the propagate side.
- **Subtraction with A = B, A < B and A > B:** separates the borrow and no-borrow outcomes.
- **Wide AND and wide OR words:** all-ones, all-zeros and a single odd bit, presented with random operand B and carry select, show that only operand A reaches the reduced result.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    MODE_ADD = 2'd0,
    MODE_SUB = 2'd1,
    MODE_AND = 2'd2,
    MODE_OR  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_EXT  = 2'd2,
    CIN_RSVD = 2'd3
  } cin_sel_e;
endpackage

// File: rtl/cc_operand_prep.sv
module cc_operand_prep
  import cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  mode_e        mode_i,
  output logic [W-1:0] prop_o,
  output logic [W-1:0] gen_o,
  output logic         force_en_o,
  output logic         force_val_o
);
  always_comb begin
    prop_o      = '0;
    gen_o       = '0;
    force_en_o  = 1'b0;
    force_val_o = 1'b0;
    unique case (mode_i)
      MODE_ADD: begin
        prop_o = a_i ^ b_i;
        gen_o  = a_i;
      end
      MODE_SUB: begin
        prop_o      = ~(a_i ^ b_i);
        gen_o       = a_i;
        force_en_o  = 1'b1;
        force_val_o = 1'b1;
      end
      // wide AND: pass carry while bit set, kill to 0 otherwise
      MODE_AND: begin
        prop_o      = a_i;
        gen_o       = '0;
        force_en_o  = 1'b1;
        force_val_o = 1'b1;
      end
      // wide OR: any set bit injects a 1 that passes upward
      MODE_OR: begin
        prop_o      = ~a_i;
        gen_o       = '1;
        force_en_o  = 1'b1;
        force_val_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cc_bit.sv
module cc_bit (
  input  logic ci_i,
  input  logic prop_i,
  input  logic gen_i,
  output logic co_o,
  output logic sum_o
);
  assign co_o  = prop_i ? ci_i : gen_i;
  assign sum_o = prop_i ^ ci_i;
endmodule

// File: rtl/cc_slice.sv
module cc_slice
  import cc_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  cin_sel_e           cin_sel_i,
  input  logic               ext_i,
  input  logic [SLICE_W-1:0] prop_i,
  input  logic [SLICE_W-1:0] gen_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic [SLICE_W-1:0] co_o,
  output logic               cout_o
);
  logic [SLICE_W:0] chain;

  always_comb begin
    unique case (cin_sel_i)
      CIN_ONE: chain[0] = 1'b1;
      CIN_EXT: chain[0] = ext_i;
      default: chain[0] = 1'b0;
    endcase
  end

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    cc_bit u_bit (
      .ci_i  (chain[i]),
      .prop_i(prop_i[i]),
      .gen_i (gen_i[i]),
      .co_o  (chain[i+1]),
      .sum_o (sum_o[i])
    );
  end

  assign co_o   = chain[SLICE_W:1];
  assign cout_o = chain[SLICE_W];
endmodule

// File: rtl/carry_chain_top.sv
module carry_chain_top
  import cc_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int SLICE_W    = 4
) (
  input  logic [NUM_SLICES*SLICE_W-1:0] op_a_i,
  input  logic [NUM_SLICES*SLICE_W-1:0] op_b_i,
  input  logic [1:0]                    mode_i,
  input  logic [1:0]                    cin_sel_i,
  input  logic                          carry_ext_i,
  output logic [NUM_SLICES*SLICE_W-1:0] sum_o,
  output logic [NUM_SLICES*SLICE_W-1:0] carry_o,
  output logic                          cout_o
);
  localparam int W = NUM_SLICES * SLICE_W;

  mode_e          mode;
  logic [W-1:0]   prop, gen;
  logic           force_en, force_val;
  cin_sel_e       base_sel;
  logic [NUM_SLICES:0] link;

  assign mode = mode_e'(mode_i);

  cc_operand_prep #(.W(W)) u_prep (
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .mode_i     (mode),
    .prop_o     (prop),
    .gen_o      (gen),
    .force_en_o (force_en),
    .force_val_o(force_val)
  );

  always_comb begin
    if (force_en) base_sel = force_val ? CIN_ONE : CIN_ZERO;
    else          base_sel = cin_sel_e'(cin_sel_i);
  end

  assign link[0] = carry_ext_i;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    cin_sel_e sel;
    if (s == 0) begin : g_bottom
      assign sel = base_sel;
    end else begin : g_upper
      assign sel = CIN_EXT;
    end
    cc_slice #(.SLICE_W(SLICE_W)) u_slice (
      .cin_sel_i(sel),
      .ext_i    (link[s]),
      .prop_i   (prop[s*SLICE_W +: SLICE_W]),
      .gen_i    (gen[s*SLICE_W +: SLICE_W]),
      .sum_o    (sum_o[s*SLICE_W +: SLICE_W]),
      .co_o     (carry_o[s*SLICE_W +: SLICE_W]),
      .cout_o   (link[s+1])
    );
  end

  assign cout_o = link[NUM_SLICES];

  // reference checks against arithmetic and reduction semantics
  logic cin_model;
  always_comb begin
    case (cin_sel_i)
      2'd1:    cin_model = 1'b1;
      2'd2:    cin_model = carry_ext_i;
      default: cin_model = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_a_i, op_b_i, mode_i, cin_sel_i, carry_ext_i})) begin
      if (mode_i == 2'd0) begin
        a_r1_add_result: assert ({cout_o, sum_o} ==
          ({1'b0, op_a_i} + {1'b0, op_b_i} + {{W{1'b0}}, cin_model}));
        a_r8_agree_gen: assert (((carry_o ^ op_a_i) & ~(op_a_i ^ op_b_i)) == '0);
      end
      if (mode_i == 2'd1) begin
        a_r3_sub_result: assert ({cout_o, sum_o} ==
          ({1'b0, op_a_i} + {1'b0, ~op_b_i} + {{W{1'b0}}, 1'b1}));
      end
      if (mode_i == 2'd2) begin
        a_r4_wide_and: assert (cout_o == &op_a_i);
      end
      if (mode_i == 2'd3) begin
        a_r5_wide_or: assert (cout_o == |op_a_i);
      end
      a_r7_top_carry: assert (cout_o == carry_o[W-1]);
    end
  end
endmodule

// File: tb/carry_chain_top_test.sv
module carry_chain_top_test;
  localparam int NS = 4;
  localparam int SW = 4;
  localparam int W  = NS * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, sum, carry;
  logic [1:0]   mode, sel;
  logic         ext, cout;
  int total = 0;
  int bad = 0;
  bit done = 0;

  carry_chain_top #(.NUM_SLICES(NS), .SLICE_W(SW)) uut (
    .op_a_i(a), .op_b_i(b), .mode_i(mode), .cin_sel_i(sel),
    .carry_ext_i(ext), .sum_o(sum), .carry_o(carry), .cout_o(cout)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [W:0] model_sum(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W-1:0] model_carries(logic [W-1:0] x, logic [W-1:0] y, logic c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      logic [W:0] m, t;
      m = ({{W{1'b0}}, 1'b1} << (i + 1)) - 1;
      t = ({1'b0, x} & m) + ({1'b0, y} & m) + {{W{1'b0}}, c};
      r[i] = t[i+1];
    end
    return r;
  endfunction

  function automatic logic pick_cin(logic [1:0] s, logic e);
    if (s == 2'd1) return 1'b1;
    if (s == 2'd2) return e;
    return 1'b0;
  endfunction

  task automatic run(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic [1:0] tm,
                     input logic [1:0] ts, input logic te);
    logic c;
    logic [W:0] r;
    @(negedge clk);
    a = ta; b = tb_; mode = tm; sel = ts; ext = te;
    #1;
    case (tm)
      2'd0: begin
        c = pick_cin(ts, te);
        r = model_sum(ta, tb_, c);
        chk("R1 R2 add", {15'd0, cout, sum}, {15'd0, r});
        chk("R6 add carries", {16'd0, carry}, {16'd0, model_carries(ta, tb_, c)});
        chk("R7 top carry", {31'd0, cout}, {31'd0, r[W]});
      end
      2'd1: begin
        r = model_sum(ta, ~tb_, 1'b1);
        chk("R3 sub", {15'd0, cout, sum}, {15'd0, r});
        chk("R6 sub carries", {16'd0, carry}, {16'd0, model_carries(ta, ~tb_, 1'b1)});
        chk("R7 top carry", {31'd0, carry[W-1]}, {31'd0, r[W]});
      end
      2'd2: chk("R4 wide and", {31'd0, cout}, {31'd0, &ta});
      default: chk("R5 wide or", {31'd0, cout}, {31'd0, |ta});
    endcase
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd4242));
    a = '0; b = '0; mode = 2'd0; sel = 2'd0; ext = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle zero sum", {15'd0, cout, sum}, 32'd0);
    chk("R6 idle zero carries", {16'd0, carry}, 32'd0);

    // R1 full ripple through every segment boundary
    run(16'hFFFF, 16'h0001, 2'd0, 2'd0, 1'b0);
    run(16'hFFFF, 16'h0000, 2'd0, 2'd1, 1'b0);
    // R2 external and reserved select
    run(16'h0FFF, 16'h0000, 2'd0, 2'd2, 1'b1);
    run(16'h0FFF, 16'h0000, 2'd0, 2'd2, 1'b0);
    run(16'hFFFF, 16'h0000, 2'd0, 2'd3, 1'b1);
    // R8 agreeing operands: carry equals A, independent of carry in
    run(16'hA5C3, 16'hA5C3, 2'd0, 2'd2, 1'b1);
    @(negedge clk); #1;
    chk("R8 agree gen", {16'd0, carry}, {16'd0, 16'hA5C3});
    // R3 borrow cases, select ignored
    run(16'h1234, 16'h1234, 2'd1, 2'd0, 1'b0);
    run(16'h0001, 16'h0002, 2'd1, 2'd2, 1'b0);
    run(16'h8000, 16'h7FFF, 2'd1, 2'd3, 1'b1);
    // R4/R5 corner words with unrelated B and select
    run(16'hFFFF, 16'h1357, 2'd2, 2'd0, 1'b0);
    run(16'hFFFE, 16'hFFFF, 2'd2, 2'd2, 1'b1);
    run(16'h7FFF, 16'h0000, 2'd2, 2'd1, 1'b1);
    run(16'h0000, 16'hFFFF, 2'd3, 2'd1, 1'b1);
    run(16'h8000, 16'h0000, 2'd3, 2'd0, 1'b0);
    run(16'h0001, 16'h0000, 2'd3, 2'd2, 1'b0);

    for (int k = 0; k < 400; k++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (k % 7 == 0) ra = 16'hFFFF ^ (16'd1 << ($urandom % W));
      run(ra, rb, 2'($urandom), 2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule